// File: doc/BRIEF.md
# Register-Controlled Two-Wire Bus Master

This block is a byte-level master for a two-wire (I2C) bus that software steers one step at a time through a small register set. Each step starts when software writes a command word to the control register. The command asks for a START condition, a byte transfer or a STOP condition. The block carries out that single bus operation and then raises a completion flag. It leaves a status code behind that software reads before it decides on the next step.

While the completion flag is up, the block keeps SCL pulled low, so the bus waits for software. Software loads the next byte into the data register and then writes a command word with a one at the flag position. That write clears the flag and launches the new step in the same cycle. The SCL rate comes from a bit-rate register and a two-bit prescaler. SCL and SDA are open-drain, so each line is modelled as an output enable that pulls it low.

Register selects on `wr_sel`: 0 is control, 1 is status (the write sets the prescaler), 2 is data and 3 is bit-rate. The control register bits are: 7 is the completion flag, 5 requests START, 4 requests STOP and 2 is enable.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the control register reads 0x00 and the status register reads 0xF8. Both `scl_oe` and `sda_oe` are 0.
- R2: A command write (bit 7, bit 5 and bit 2 set) issued while the bus is idle produces a START condition: SDA falls while SCL is released. SCL is then pulled low, the flag is set and the status code reads 0x08.
- R3: While the completion flag is set, `scl_oe` stays 1 and `sda_oe` does not change.
- R4: A control write with a zero at bit 7 leaves a set flag set and starts no bus activity.
- R5: A control write without the enable bit (bit 2) is ignored as a command: it neither clears the flag nor starts any bus activity.
- R6: A byte command shifts out, MSB first, the data register value held in the cycle of the clearing write. A data register write after that cycle does not alter the byte on the bus.
- R7: The ACK bit is sampled during the ninth SCL high phase. After the first byte that follows a START, the status code reads 0x18 on ACK (SDA low) and 0x20 on NACK.
- R8: After any later byte, the status code reads 0x28 on ACK and 0x30 on NACK.
- R9: SDA changes only while SCL is pulled low, except at the START edge and the STOP edge.
- R10: A command with the STOP bit (bit 4) makes SDA rise while SCL is released. The block then clears bit 4 by itself and leaves the flag clear. The status reads code 0xF8 and both lines are released.
- R11: Within a byte, SCL rising edges are 16 + 2·rate·4^prescaler system clocks apart.
- R12: Status bits [1:0] return the prescaler value, bit 2 reads zero, and the code sits in bits [7:3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 8 | Write data |
| ctrl_q | output | 8 | Control register contents |
| status_q | output | 8 | Status code and prescaler |
| data_q | output | 8 | Data register contents |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_oe | output | 1 | Pulls SDA low when 1 |

## Verification
Two things meet in a single cycle: the write that clears the flag and the loading of the shift register from the data register. A new data write follows the byte command on the very next cycle, and the byte decoded from the bus must still equal the earlier value. The STOP completion also clears a software-visible control bit in the same cycle that the status code returns to idle. Both of these are judged from the ports once the STOP edge has been seen on the bus.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int PS_W = 2;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_RATE = 2'd3;
  localparam int B_FLAG  = 7;
  localparam int B_START = 5;
  localparam int B_STOP  = 4;
  localparam int B_EN    = 2;
  // status codes, upper five bits of the status register
  localparam logic [4:0] C_START   = 5'h01;
  localparam logic [4:0] C_AD_ACK  = 5'h03;
  localparam logic [4:0] C_AD_NACK = 5'h04;
  localparam logic [4:0] C_DT_ACK  = 5'h05;
  localparam logic [4:0] C_DT_NACK = 5'h06;
  localparam logic [4:0] C_IDLE    = 5'h1F;
  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT, ST_STA_PRE, ST_STA_HI, ST_STA_HOLD,
    ST_BIT_LO, ST_BIT_HI, ST_STO_LO, ST_STO_HI, ST_STO_REL
  } seq_e;
endpackage

// File: rtl/i2cm_div.sv
module i2cm_div #(
  parameter int RATE_W = 8,
  parameter int PS_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  input  logic [PS_W-1:0]   presc,
  output logic              tick,
  output logic              mid
);
  localparam int CNT_W = RATE_W + 2 * ((1 << PS_W) - 1) + 1;

  logic [CNT_W-1:0] half_w, cnt_q, cnt_n;

  // half SCL period = 8 + rate * 4^presc
  assign half_w = CNT_W'(8) + (CNT_W'(rate) << {presc, 1'b0});
  assign tick   = run && (cnt_q >= half_w - CNT_W'(1));
  assign mid    = run && (cnt_q == (half_w >> 1));

  always_comb begin
    if (!run || tick) cnt_n = '0;
    else              cnt_n = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
#(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic              seq_idle,
  input  logic              done,
  input  logic [4:0]        done_code,
  input  logic              stop_done,
  output logic [7:0]        ctrl_q,
  output logic [7:0]        status_q,
  output logic [7:0]        data_q,
  output logic [RATE_W-1:0] rate_q,
  output logic [PS_W-1:0]   presc_q,
  output logic              cmd_go,
  output logic              cmd_start,
  output logic              cmd_stop
);
  logic              wr_ctrl, cmd_ok;
  logic [7:0]        ctrl_n, data_n;
  logic [4:0]        code_q, code_n;
  logic [RATE_W-1:0] rate_n;
  logic [PS_W-1:0]   presc_n;

  assign wr_ctrl   = wr_en && (wr_sel == SEL_CTRL);
  assign cmd_ok    = wr_ctrl && wr_data[B_FLAG] && wr_data[B_EN];
  assign cmd_go    = cmd_ok && (ctrl_q[B_FLAG] || seq_idle);
  assign cmd_start = wr_data[B_START];
  assign cmd_stop  = wr_data[B_STOP];
  assign status_q  = {code_q, 1'b0, presc_q};

  always_comb begin
    ctrl_n  = ctrl_q;
    code_n  = code_q;
    data_n  = data_q;
    rate_n  = rate_q;
    presc_n = presc_q;
    if (wr_ctrl) begin
      ctrl_n         = wr_data;
      ctrl_n[B_FLAG] = ctrl_q[B_FLAG] & ~cmd_ok;
    end
    if (done)      ctrl_n[B_FLAG] = 1'b1;
    if (stop_done) ctrl_n[B_STOP] = 1'b0;
    if (done)           code_n = done_code;
    else if (stop_done) code_n = C_IDLE;
    if (wr_en && wr_sel == SEL_DATA) data_n  = wr_data;
    if (wr_en && wr_sel == SEL_RATE) rate_n  = RATE_W'(wr_data);
    if (wr_en && wr_sel == SEL_STAT) presc_n = wr_data[PS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      code_q  <= C_IDLE;
      data_q  <= '0;
      rate_q  <= '0;
      presc_q <= '0;
    end else begin
      ctrl_q  <= ctrl_n;
      code_q  <= code_n;
      data_q  <= data_n;
      rate_q  <= rate_n;
      presc_q <= presc_n;
    end
  end
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_go,
  input  logic       cmd_start,
  input  logic       cmd_stop,
  input  logic [7:0] tx_byte,
  input  logic       tick,
  input  logic       mid,
  input  logic       sda_in,
  output logic       run,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       done,
  output logic [4:0] done_code,
  output logic       stop_done,
  output logic       idle,
  output logic       cond
);
  seq_e       st_q, st_n;
  logic [7:0] sh_q, sh_n;
  logic [3:0] bit_q, bit_n;
  logic       addr_q, addr_n, scl_q, scl_n, sda_q, sda_n;

  assign scl_oe = scl_q;
  assign sda_oe = sda_q;
  assign run    = (st_q != ST_IDLE) && (st_q != ST_WAIT);
  assign idle   = (st_q == ST_IDLE);
  assign cond   = (st_q == ST_STA_HOLD) || (st_q == ST_STO_REL);

  always_comb begin
    st_n = st_q; sh_n = sh_q; bit_n = bit_q; addr_n = addr_q;
    scl_n = scl_q; sda_n = sda_q;
    done = 1'b0; done_code = C_IDLE; stop_done = 1'b0;
    case (st_q)
      ST_IDLE: begin
        scl_n = 1'b0; sda_n = 1'b0;
        if (cmd_go && cmd_start) st_n = ST_STA_HI;
      end
      ST_WAIT: if (cmd_go) begin
        if (cmd_start)     st_n = ST_STA_PRE;
        else if (cmd_stop) st_n = ST_STO_LO;
        else begin
          st_n = ST_BIT_LO; sh_n = tx_byte; bit_n = '0;
        end
      end
      ST_STA_PRE: begin
        if (mid) sda_n = 1'b0;
        if (tick) begin st_n = ST_STA_HI; scl_n = 1'b0; end
      end
      ST_STA_HI: if (tick) begin st_n = ST_STA_HOLD; sda_n = 1'b1; end
      ST_STA_HOLD: if (tick) begin
        st_n = ST_WAIT; scl_n = 1'b1; addr_n = 1'b1;
        done = 1'b1; done_code = C_START;
      end
      ST_BIT_LO: begin
        if (mid) sda_n = bit_q[3] ? 1'b0 : ~sh_q[7];
        if (tick) begin st_n = ST_BIT_HI; scl_n = 1'b0; end
      end
      ST_BIT_HI: if (tick) begin
        scl_n = 1'b1;
        if (bit_q[3]) begin
          st_n = ST_WAIT; addr_n = 1'b0; done = 1'b1;
          if (addr_q) done_code = sda_in ? C_AD_NACK : C_AD_ACK;
          else        done_code = sda_in ? C_DT_NACK : C_DT_ACK;
        end else begin
          st_n = ST_BIT_LO; bit_n = bit_q + 4'd1; sh_n = {sh_q[6:0], 1'b0};
        end
      end
      ST_STO_LO: begin
        if (mid) sda_n = 1'b1;
        if (tick) begin st_n = ST_STO_HI; scl_n = 1'b0; end
      end
      ST_STO_HI: if (tick) begin st_n = ST_STO_REL; sda_n = 1'b0; end
      ST_STO_REL: if (tick) begin st_n = ST_IDLE; stop_done = 1'b1; end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; sh_q <= '0; bit_q <= '0; addr_q <= 1'b0;
      scl_q <= 1'b0; sda_q <= 1'b0;
    end else begin
      st_q <= st_n; sh_q <= sh_n; bit_q <= bit_n; addr_q <= addr_n;
      scl_q <= scl_n; sda_q <= sda_n;
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int RATE_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] ctrl_q,
  output logic [7:0] status_q,
  output logic [7:0] data_q,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  logic              rst_meta, rst_sync_n;
  logic [RATE_W-1:0] rate_q;
  logic [PS_W-1:0]   presc_q;
  logic              cmd_go, cmd_start, cmd_stop, run, tick, mid;
  logic              done, stop_done, seq_idle, cond;
  logic [4:0]        done_code;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  i2cm_regs #(.RATE_W(RATE_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .seq_idle(seq_idle), .done(done),
    .done_code(done_code), .stop_done(stop_done), .ctrl_q(ctrl_q),
    .status_q(status_q), .data_q(data_q), .rate_q(rate_q),
    .presc_q(presc_q), .cmd_go(cmd_go), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop)
  );

  i2cm_div #(.RATE_W(RATE_W), .PS_W(PS_W)) u_div (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .rate(rate_q),
    .presc(presc_q), .tick(tick), .mid(mid)
  );

  i2cm_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n), .cmd_go(cmd_go), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .tx_byte(data_q), .tick(tick), .mid(mid),
    .sda_in(sda_in), .run(run), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .done(done), .done_code(done_code), .stop_done(stop_done),
    .idle(seq_idle), .cond(cond)
  );
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctrl_q,
  input logic [4:0] code,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic       wr_en_bit,
  input logic       idle,
  input logic       cond
);
  p_flag_holds_scl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7] |-> scl_oe);

  p_flag_freezes_sda_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[7] && $past(ctrl_q[7])) |-> $stable(sda_oe));

  p_no_enable_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && wr_en && wr_sel == 2'd0 && !wr_en_bit) |=> (idle && !scl_oe && !sda_oe));

  p_code_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[7]) |-> (code inside {5'h01, 5'h03, 5'h04, 5'h05, 5'h06}));

  p_sda_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> cond);

  p_stop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctrl_q[4]) && !$past(wr_en)) |-> (!ctrl_q[7] && code == 5'h1F && idle));
endmodule

bind i2c_byte_master i2cm_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .ctrl_q(ctrl_q), .code(status_q[7:3]),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_en_bit(wr_data[2]), .idle(seq_idle), .cond(cond)
);

// File: tb/i2c_byte_master_bench.sv
module i2c_byte_master_bench;
  localparam int EV_START = 1, EV_BYTE = 2, EV_STOP = 3;

  logic       clk, rst_n, wr_en, sda_in, scl_oe, sda_oe;
  logic [1:0] wr_sel;
  logic [7:0] wr_data, ctrl_q, status_q, data_q;
  logic       slave_pull, ack_next, mon_on;
  logic       scl_b, sda_b, scl_p, sda_p;
  logic [7:0] shv;
  logic [9:0] exp_q[$];
  int         checks, fails, cyc, bcnt, last_rise, last_period, events;

  i2c_byte_master u_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ctrl_q(ctrl_q), .status_q(status_q),
    .data_q(data_q), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  assign sda_in = ~(sda_oe | slave_pull);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      summary();
    end
  end

  // scoreboard monitor: decode bus events and pop expected items
  task automatic got(input int t, input int v);
    logic [9:0] e;
    events++;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R9 unexpected bus event", t * 256 + v, 0);
    end else begin
      e = exp_q.pop_front();
      chk(e == {2'(t), 8'(v)}, (t == EV_BYTE) ? "R6 byte" : "R9 condition",
          t * 256 + v, int'(e));
    end
  endtask

  always @(negedge clk) begin
    scl_b = ~scl_oe;
    sda_b = sda_in;
    if (mon_on) begin
      if (scl_b && scl_p && sda_p && !sda_b) begin got(EV_START, 0); bcnt = 0; end
      else if (scl_b && scl_p && !sda_p && sda_b) got(EV_STOP, 0);
      if (scl_b && !scl_p) begin
        bcnt++;
        if (bcnt > 1) last_period = cyc - last_rise;
        last_rise = cyc;
        if (bcnt <= 8) shv = {shv[6:0], sda_b};
        else got(EV_BYTE, int'(shv));
      end
      if (!scl_b && scl_p) begin
        if (bcnt == 8) slave_pull = ack_next;
        if (bcnt == 9) begin slave_pull = 1'b0; bcnt = 0; end
      end
    end
    scl_p = scl_b;
    sda_p = sda_b;
  end

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push(input int t, input int v);
    exp_q.push_back({2'(t), 8'(v)});
  endtask

  task automatic wait_flag();
    while (!ctrl_q[7]) @(negedge clk);
  endtask

  task automatic wait_stop();
    while (ctrl_q[4]) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic ok;
    logic held;
    int   ev0;
    checks = 0; fails = 0; cyc = 0; bcnt = 0; events = 0;
    last_rise = 0; last_period = 0; shv = '0;
    slave_pull = 1'b0; ack_next = 1'b1; mon_on = 1'b0;
    scl_p = 1'b1; sda_p = 1'b1;
    wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R1 reset state
    chk(ctrl_q == 8'h00, "R1 ctrl", ctrl_q, 8'h00);
    chk(status_q == 8'hF8, "R1 status", status_q, 8'hF8);
    chk(!scl_oe && !sda_oe, "R1 lines", {scl_oe, sda_oe}, 0);

    // R5 command without enable bit: nothing happens
    ev0 = events;
    wr(2'd0, 8'hA0);
    ok = 1'b1;
    repeat (100) begin @(negedge clk); if (scl_oe || sda_oe) ok = 1'b0; end
    chk(ok && events == ev0 && status_q == 8'hF8, "R5 no enable", events - ev0, 0);

    // R2 START from idle
    push(EV_START, 0);
    wr(2'd0, 8'hA4);
    wait_flag();
    chk(status_q == 8'h08, "R2 start status", status_q, 8'h08);

    // R3 bus held while flag is set
    held = sda_oe; ok = 1'b1;
    repeat (200) begin @(negedge clk); if (!scl_oe || sda_oe != held) ok = 1'b0; end
    chk(ok, "R3 hold", {scl_oe, sda_oe}, {1'b1, held});

    // R4 write with flag bit zero leaves the flag and bus alone
    ev0 = events;
    wr(2'd0, 8'h04);
    repeat (100) @(negedge clk);
    chk(ctrl_q[7] && events == ev0, "R4 zero at flag", ctrl_q, 8'h84);

    // R5 clearing write without enable leaves flag set
    wr(2'd0, 8'h80);
    repeat (50) @(negedge clk);
    chk(ctrl_q[7] && events == ev0, "R5 flag kept", ctrl_q, 8'h80);

    // R6/R7 address byte with ACK; data write right after the command
    wr(2'd2, 8'hA6);
    ack_next = 1'b1;
    push(EV_BYTE, 8'hA6);
    wr(2'd0, 8'h84);
    wr(2'd2, 8'h11);
    wait_flag();
    chk(status_q == 8'h18, "R7 address ack", status_q, 8'h18);
    chk(last_period == 16, "R11 default period", last_period, 16);
    chk(data_q == 8'h11, "R6 data register", data_q, 8'h11);

    // R8 data byte with NACK
    wr(2'd2, 8'h3C);
    ack_next = 1'b0;
    push(EV_BYTE, 8'h3C);
    wr(2'd0, 8'h84);
    wait_flag();
    chk(status_q == 8'h30, "R8 data nack", status_q, 8'h30);

    // R10 STOP
    push(EV_STOP, 0);
    wr(2'd0, 8'h94);
    wait_stop();
    chk(ctrl_q[4] == 1'b0 && ctrl_q[7] == 1'b0, "R10 stop bits", ctrl_q, 8'h04);
    chk(status_q == 8'hF8, "R10 status idle", status_q, 8'hF8);
    chk(!scl_oe && !sda_oe, "R10 lines free", {scl_oe, sda_oe}, 0);

    // R12 prescaler in status low bits; R11 slower rate
    wr(2'd3, 8'h02);
    wr(2'd1, 8'h01);
    chk(status_q == 8'hF9, "R12 prescaler bits", status_q, 8'hF9);

    push(EV_START, 0);
    wr(2'd0, 8'hA4);
    wait_flag();
    chk(status_q == 8'h09, "R2 start code slow", status_q, 8'h09);

    // R7 address NACK
    wr(2'd2, 8'h50);
    ack_next = 1'b0;
    push(EV_BYTE, 8'h50);
    wr(2'd0, 8'h84);
    wait_flag();
    chk(status_q[7:3] == 5'h04, "R7 address nack", status_q, 8'h21);
    chk(last_period == 32, "R11 scaled period", last_period, 32);

    // R8 data ACK
    wr(2'd2, 8'h81);
    ack_next = 1'b1;
    push(EV_BYTE, 8'h81);
    wr(2'd0, 8'h84);
    wait_flag();
    chk(status_q[7:3] == 5'h05, "R8 data ack", status_q, 8'h29);

    // R2 repeated START from the held state
    push(EV_START, 0);
    wr(2'd0, 8'hA4);
    wait_flag();
    chk(status_q[7:3] == 5'h01, "R2 repeated start", status_q, 8'h09);

    push(EV_STOP, 0);
    wr(2'd0, 8'h94);
    wait_stop();
    chk(status_q == 8'hF9 && !ctrl_q[7], "R10 second stop", status_q, 8'hF9);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all events seen", exp_q.size(), 0);
    summary();
  end
endmodule